// File: doc/BRIEF.md
# Push-Button Command Conditioner

This block sits between four mechanical push-buttons and a datapath controller. It turns each raw contact signal into a clean command. Every button input first crosses into the clock domain through a short flip-flop chain. A lockout debouncer then accepts the first level change it sees and ignores the contact for a fixed number of clock cycles, so the chatter that follows is discarded. A rising-edge stage finally converts the settled level into a pulse that lasts one clock cycle.

Three of the buttons deliver one-cycle commands: load operand A, load operand B and single step. The fourth button starts free-running operation. Its one-cycle pulse enables a register whose data input is held at logic one, so the run flag rises on the first press and stays high until reset. One synchronous reset clears every stage and the run flag. The lockout length and the depth of the synchroniser are parameters. A build for silicon uses a lockout of milliseconds, and a simulation build uses a few cycles.

Top module: `btn_cmd_conditioner`

## Requirements
- R1: While `rst_i` is high, and in the cycle after it is sampled high, all four outputs are 0 and every internal stage returns to its idle, released state.
- R2: Bit 0 of `btn_i` drives `load_a_o`, bit 1 drives `load_b_o` and bit 2 drives `step_o`. One press, meaning a 0-to-1 transition held long enough, gives exactly one pulse of one clock cycle on the matching output.
- R3: The debouncer takes the first change of its synchronised input at once. It then ignores that input for `HOLD_CYCLES` clock cycles, so bounces inside this window add no pulse. Two pulses on the same output are therefore always more than `HOLD_CYCLES` cycles apart.
- R4: Releasing a button, with or without bounce, gives no pulse on any output.
- R5: Bit 3 of `btn_i` sets `run_o`. Once set, `run_o` stays 1 until reset, and later presses of any button leave it unchanged.
- R6: After a clean press, the command pulse is high during the cycle that follows the (`SYNC_STAGES`+2)-th rising clock edge after the input change. `run_o` rises one cycle later than the internal run pulse.
- R7: The buttons are independent. Presses that start in the same cycle each give their own pulse in the same cycle.
- R8: Presses of buttons 0 to 2 never change `run_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| btn_i | input | 4 | Raw button contacts: bit 0 load A, bit 1 load B, bit 2 step, bit 3 run |
| load_a_o | output | 1 | One-cycle load-A command |
| load_b_o | output | 1 | One-cycle load-B command |
| step_o | output | 1 | One-cycle step command |
| run_o | output | 1 | Sticky run flag |

## Verification
The bench builds the block with `HOLD_CYCLES` set to 16 and `SYNC_STAGES` set to 2. A bounce burst of a few cycles then falls inside the lockout window, and the press, the bounce, the settled level and the release all fit in about a hundred cycles. With these values the bench can drive many bouncy press and release sequences on every button, check exactly when each pulse appears, and show that the run flag stays set across later presses and clears only on reset.

// File: rtl/btn_cmd_pkg.sv
package btn_cmd_pkg;
    // Number of conditioned buttons and their positions in the raw input vector
    localparam int unsigned BTN_COUNT = 4;
    localparam int unsigned IDX_LOAD_A = 0;
    localparam int unsigned IDX_LOAD_B = 1;
    localparam int unsigned IDX_STEP   = 2;
    localparam int unsigned IDX_RUN    = 3;
endpackage

// File: rtl/btn_sync.sv
// Flip-flop chain that brings one asynchronous contact into the clock domain.
module btn_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/btn_debounce.sv
// Lockout debouncer: the first change is taken at once, then the input is
// ignored for HOLD_CYCLES cycles.
module btn_debounce #(
    parameter int unsigned HOLD_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level
);
    localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);

    typedef struct packed {
        logic          level;
        logic [CW-1:0] wait_cnt;
    } deb_state_t;

    deb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.wait_cnt != '0) begin
            st_d.wait_cnt = st_q.wait_cnt - CW'(1);
        end else if (din != st_q.level) begin
            st_d.level    = din;
            st_d.wait_cnt = CW'(HOLD_CYCLES);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign level = st_q.level;
endmodule

// File: rtl/rise_pulse.sv
// Registered rising-edge detector: one-cycle pulse per 0-to-1 step.
module rise_pulse (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic pulse
);
    typedef struct packed {
        logic prev;
        logic pulse;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d.prev  = level;
        st_d.pulse = level & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pulse = st_q.pulse;
endmodule

// File: rtl/btn_cmd_conditioner.sv
module btn_cmd_conditioner
    import btn_cmd_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 250000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [BTN_COUNT-1:0] btn_i,
    output logic                 load_a_o,
    output logic                 load_b_o,
    output logic                 step_o,
    output logic                 run_o
);
    logic [BTN_COUNT-1:0] synced;
    logic [BTN_COUNT-1:0] settled;
    logic [BTN_COUNT-1:0] cmd_pulse;

    generate
        for (genvar i = 0; i < BTN_COUNT; i++) begin : g_btn
            btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk_i),
                .rst  (rst_i),
                .din  (btn_i[i]),
                .dout (synced[i])
            );
            btn_debounce #(.HOLD_CYCLES(HOLD_CYCLES)) u_deb (
                .clk   (clk_i),
                .rst   (rst_i),
                .din   (synced[i]),
                .level (settled[i])
            );
            rise_pulse u_edge (
                .clk   (clk_i),
                .rst   (rst_i),
                .level (settled[i]),
                .pulse (cmd_pulse[i])
            );
        end
    endgenerate

    // Sticky run flag: enabled register whose data input is constant one
    typedef struct packed {
        logic run;
    } run_state_t;

    run_state_t run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (cmd_pulse[IDX_RUN]) run_d.run = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) run_q <= '0;
        else       run_q <= run_d;
    end

    assign load_a_o = cmd_pulse[IDX_LOAD_A];
    assign load_b_o = cmd_pulse[IDX_LOAD_B];
    assign step_o   = cmd_pulse[IDX_STEP];
    assign run_o    = run_q.run;
endmodule

// File: rtl/btn_cmd_checker.sv
module btn_cmd_checker #(
    parameter int unsigned HOLD_CYCLES = 250000
) (
    input logic clk,
    input logic rst,
    input logic load_a,
    input logic load_b,
    input logic step,
    input logic run
);
    localparam int unsigned GW  = $clog2(HOLD_CYCLES + 3);
    localparam logic [GW-1:0] SAT = GW'(HOLD_CYCLES + 1);

    logic [2:0] cmds;
    assign cmds = {step, load_b, load_a};

    // R1: reset clears every output one cycle later
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> !(load_a || load_b || step || run));

    // R5: run flag never drops outside reset
    assert_run_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        run |=> run);

    generate
        for (genvar i = 0; i < 3; i++) begin : g_cmd
            logic [GW-1:0] gap_q;

            always_ff @(posedge clk) begin
                if (rst)            gap_q <= SAT;
                else if (cmds[i])   gap_q <= '0;
                else if (gap_q != SAT) gap_q <= gap_q + GW'(1);
            end

            // R2: each command pulse lasts one cycle
            assert_single_cycle_R2: assert property (@(posedge clk) disable iff (rst)
                cmds[i] |=> !cmds[i]);

            // R3: pulses on one output are separated by more than the lockout
            assert_holdoff_spacing_R3: assert property (@(posedge clk) disable iff (rst)
                cmds[i] |-> (gap_q > GW'(HOLD_CYCLES)));
        end
    endgenerate
endmodule

bind btn_cmd_conditioner btn_cmd_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk    (clk_i),
    .rst    (rst_i),
    .load_a (load_a_o),
    .load_b (load_b_o),
    .step   (step_o),
    .run    (run_o)
);

// File: tb/btn_cmd_conditioner_bench.sv
module btn_cmd_conditioner_bench;
    localparam int HOLD = 16;
    localparam int SYNC = 2;
    localparam int WATCHDOG = 50000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] btn = 4'b0;
    logic       load_a, load_b, step, run;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit started = 1'b0;
    int pc[4];

    // reference model state
    bit m_sync[4][SYNC];
    bit m_lvl[4];
    int m_cnt[4];
    bit m_prev[4];
    bit m_pulse[4];
    bit m_run;

    always #5 clk = ~clk;

    btn_cmd_conditioner #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(SYNC)) u_btn_cmd_conditioner (
        .clk_i    (clk),
        .rst_i    (rst),
        .btn_i    (btn),
        .load_a_o (load_a),
        .load_b_o (load_b),
        .step_o   (step),
        .run_o    (run)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model, updated on each rising edge
    always @(posedge clk) begin
        started <= 1'b1;
        cyc++;
        if (rst) begin
            for (int i = 0; i < 4; i++) begin
                for (int k = 0; k < SYNC; k++) m_sync[i][k] = 1'b0;
                m_lvl[i] = 0; m_cnt[i] = 0; m_prev[i] = 0; m_pulse[i] = 0;
            end
            m_run = 0;
        end else begin
            m_run = m_run | m_pulse[3];
            for (int i = 0; i < 4; i++) begin
                bit seen;
                seen = m_sync[i][SYNC-1];
                m_pulse[i] = m_lvl[i] & ~m_prev[i];
                m_prev[i]  = m_lvl[i];
                if (m_cnt[i] > 0) m_cnt[i]--;
                else if (seen != m_lvl[i]) begin
                    m_lvl[i] = seen;
                    m_cnt[i] = HOLD;
                end
                for (int k = SYNC - 1; k > 0; k--) m_sync[i][k] = m_sync[i][k-1];
                m_sync[i][0] = btn[i];
            end
        end
        if (cyc == WATCHDOG) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (started) begin
            check(load_a == m_pulse[0], "R2 load_a model", int'(load_a), int'(m_pulse[0]));
            check(load_b == m_pulse[1], "R2 load_b model", int'(load_b), int'(m_pulse[1]));
            check(step   == m_pulse[2], "R2 step model",   int'(step),   int'(m_pulse[2]));
            check(run    == m_run,      "R5 run model",    int'(run),    int'(m_run));
            if (load_a === 1'b1) pc[0]++;
            if (load_b === 1'b1) pc[1]++;
            if (step   === 1'b1) pc[2]++;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bouncy(input int i, input bit val);
        btn[i] = val;  wait_cyc(1);
        btn[i] = !val; wait_cyc(2);
        btn[i] = val;  wait_cyc(1);
        btn[i] = !val; wait_cyc(1);
        btn[i] = val;  wait_cyc(3 * HOLD);
    endtask

    initial begin
        int base[4];
        int n;
        for (int i = 0; i < 4; i++) pc[i] = 0;
        wait_cyc(5);
        // R1: outputs idle during reset
        check({load_a, load_b, step, run} == 4'b0, "R1 reset outputs", int'({load_a, load_b, step, run}), 0);
        rst = 1'b0;
        wait_cyc(3);

        // R6: latency of a clean press
        btn[2] = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!step && n < 50);
        check(n == SYNC + 2, "R6 pulse latency", n, SYNC + 2);
        wait_cyc(3 * HOLD);
        base[2] = pc[2];
        bouncy(2, 1'b0);
        check(pc[2] == base[2], "R4 release of step", pc[2] - base[2], 0);

        // R2 R3 R4 R8: bouncy press and release on each command button
        for (int i = 0; i < 3; i++) begin
            base[i] = pc[i];
            bouncy(i, 1'b1);
            check(pc[i] - base[i] == 1, "R3 one pulse per bouncy press", pc[i] - base[i], 1);
            check(run == 1'b0, "R8 run untouched", int'(run), 0);
            base[i] = pc[i];
            bouncy(i, 1'b0);
            check(pc[i] == base[i], "R4 no pulse on release", pc[i] - base[i], 0);
        end

        // R7: simultaneous presses
        for (int i = 0; i < 3; i++) base[i] = pc[i];
        btn[2:0] = 3'b111;
        wait_cyc(SYNC + 2);
        check({step, load_b, load_a} == 3'b111, "R7 simultaneous pulses", int'({step, load_b, load_a}), 7);
        wait_cyc(3 * HOLD);
        for (int i = 0; i < 3; i++)
            check(pc[i] - base[i] == 1, "R7 one pulse each", pc[i] - base[i], 1);
        btn[2:0] = 3'b000;
        wait_cyc(3 * HOLD);

        // R5: run press sets a sticky flag
        bouncy(3, 1'b1);
        check(run == 1'b1, "R5 run set", int'(run), 1);
        bouncy(3, 1'b0);
        check(run == 1'b1, "R5 run held after release", int'(run), 1);
        bouncy(3, 1'b1);
        bouncy(3, 1'b0);
        bouncy(0, 1'b1);
        bouncy(0, 1'b0);
        check(run == 1'b1, "R5 run held after more presses", int'(run), 1);

        // R1: reset clears the run flag
        rst = 1'b1;
        wait_cyc(2);
        check({load_a, load_b, step, run} == 4'b0, "R1 reset clears run", int'({load_a, load_b, step, run}), 0);
        rst = 1'b0;
        wait_cyc(5);
        check(run == 1'b0, "R1 run stays clear", int'(run), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule